// File: doc/BRIEF.md
# Clock Source Mode and Power Controller

This block is the control logic of a multiplying clock generator. It reads an active-low power-down input, an active-low output-stop input, a two-bit output-source select and a two-bit multiplier select. From these it picks the source that the output stage drives and gives the analog parts their enables. It also produces the feedback and prescaler divider values for the PLL.

It keeps a settle timer that restarts on each kind of disturbance: release from power-down, a multiplier change, a source-select change, or the end of an output stop. The `settled` output is high only while the timer has run out. Three sticky violation flags record misuse of the inputs: a stop held for too long, a stop started again too soon after the last one, or a multiplier change while the reference-clock source is selected. All timer lengths are parameters counted in timebase ticks. The timebase is a free-running divider of the block clock. The divider is set by `TICK_DIV`, and a value of 1 gives one tick per clock.

Top module: `clk_mode_ctrl`

## Requirements
- R1: While `pwrdn_n` is 0, every other input is ignored: `out_src` is 0 (ground), `drv_en` and `pll_en` are 0 and `settled` is 0.
- R2: With `pwrdn_n`=1 and `stop_n`=0, `out_src` is 1 (parked), `pll_en` is 1 and `drv_en` is 0.
- R3: With `pwrdn_n`=1 and `stop_n`=1, `{sel_a,sel_b}` chooses `out_src`: 00 gives 2 (aligned clock), 10 gives 3 (PLL bypass), 11 gives 4 (reference clock) and 01 gives 5 (high impedance). `drv_en` is 1 except for 01, and `pll_en` is 1.
- R4: `{mul_a,mul_b}` sets `fb_div`/`pre_div` at all times: 00 gives 4/1, 01 gives 6/1, 11 gives 8/1 and 10 gives 8/3.
- R5: After reset release, or after `pwrdn_n` returns to 1, `settled` rises exactly `T_PWRUP` ticks later.
- R6: A multiplier change seen at a clock edge drops `settled`. `settled` then rises `T_MULT` ticks after that edge.
- R7: A source-select change seen at a clock edge drops `settled`. `settled` then rises `T_CTL` ticks after that edge.
- R8: `settled` is 0 during an output stop. After `stop_n` returns to 1, `settled` rises `T_PHASE` ticks after the edge that first sees it high.
- R9: When disturbances overlap or coincide, the timer keeps the longer of its remaining time and the new interval.
- R10: A stop that lasts more than `T_STOP_MAX` ticks sets `viol[0]`.
- R11: A stop that begins after fewer than `T_RUN_MIN` ticks of normal running, counted since the previous stop ended, sets `viol[1]`.
- R12: A multiplier change while the select has been 11 and power is on sets `viol[2]`. The same change under any other select sets no flag.
- R13: The violation flags stay set until reset. Select, multiplier and stop activity during power-down sets no flag and adds nothing to the `T_PWRUP` settle time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the timebase runs from it |
| rst_n | input | 1 | Synchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down |
| stop_n | input | 1 | Active-low output stop |
| sel_a | input | 1 | Source select, upper bit |
| sel_b | input | 1 | Source select, lower bit |
| mul_a | input | 1 | Multiplier select, upper bit |
| mul_b | input | 1 | Multiplier select, lower bit |
| out_src | output | 3 | Output source: 0 ground, 1 parked, 2 aligned, 3 bypass, 4 reference, 5 high-Z |
| fb_div | output | 4 | PLL feedback divider |
| pre_div | output | 2 | PLL prescaler divider |
| pll_en | output | 1 | PLL powered |
| drv_en | output | 1 | Output driver enabled |
| settled | output | 1 | Output clock settled |
| viol | output | 3 | Sticky flags: [0] stop too long, [1] run too short, [2] multiplier change in test |

## Verification
A source-select change and a multiplier change can reach the settle timer in the same clock edge, or while the other's interval is still counting down. The bench provokes both orders, with the second change issued a few cycles into the first interval, and also applies both changes in one cycle. Each time it predicts the rise of `settled` from the larger of the remaining and the new interval. A stop entry can also coincide with the check on the previous run length. The bench places a stop exactly at and exactly one tick short of the minimum run, and a stop exactly at and one tick past the dwell limit, then judges the individual flag bits.

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl #(
  parameter int TICK_DIV   = 1,
  parameter int T_PWRUP    = 300000,
  parameter int T_MULT     = 100000,
  parameter int T_CTL      = 300000,
  parameter int T_PHASE    = 20,
  parameter int T_STOP_MAX = 10000,
  parameter int T_RUN_MIN  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwrdn_n,
  input  logic       stop_n,
  input  logic       sel_a,
  input  logic       sel_b,
  input  logic       mul_a,
  input  logic       mul_b,
  output logic [2:0] out_src,
  output logic [3:0] fb_div,
  output logic [1:0] pre_div,
  output logic       pll_en,
  output logic       drv_en,
  output logic       settled,
  output logic [2:0] viol
);
  localparam int M1   = (T_PWRUP > T_CTL) ? T_PWRUP : T_CTL;
  localparam int M2   = (T_MULT > T_PHASE) ? T_MULT : T_PHASE;
  localparam int MAXT = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXT + 1);
  localparam int SW   = $clog2(T_STOP_MAX + 1);
  localparam int RW   = $clog2(T_RUN_MIN + 1);
  localparam logic [CW-1:0] L_PWRUP = CW'(T_PWRUP);
  localparam logic [CW-1:0] L_MULT  = CW'(T_MULT);
  localparam logic [CW-1:0] L_CTL   = CW'(T_CTL);
  localparam logic [CW-1:0] L_PHASE = CW'(T_PHASE);
  localparam logic [SW-1:0] L_SMAX  = SW'(T_STOP_MAX);
  localparam logic [RW-1:0] L_RMIN  = RW'(T_RUN_MIN);

  localparam logic [2:0] SRC_GND = 3'd0, SRC_PARK = 3'd1, SRC_ALIGN = 3'd2,
                         SRC_BYP = 3'd3, SRC_REF = 3'd4, SRC_HIZ = 3'd5;

  logic [1:0] sel, mul, p_sel, p_mul;
  logic p_stop_n, tick;
  logic [CW-1:0] cnt, cnt_nxt;
  logic [SW-1:0] stop_cnt;
  logic [RW-1:0] run_cnt;

  assign sel = {sel_a, sel_b};
  assign mul = {mul_a, mul_b};

  wire pd       = !pwrdn_n;
  wire stopped  = pwrdn_n && !stop_n;
  wire running  = pwrdn_n && stop_n;
  wire mul_chg  = mul != p_mul;
  wire sel_chg  = sel != p_sel;
  wire stop_end = stop_n && !p_stop_n;

  generate
    if (TICK_DIV > 1) begin : g_tb
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] tb_cnt;
      always_ff @(posedge clk)
        if (!rst_n || tb_cnt == DW'(TICK_DIV - 1)) tb_cnt <= '0;
        else tb_cnt <= tb_cnt + DW'(1);
      assign tick = tb_cnt == DW'(TICK_DIV - 1);
    end else begin : g_notb
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    if (pd) out_src = SRC_GND;
    else if (!stop_n) out_src = SRC_PARK;
    else case (sel)
      2'b00:   out_src = SRC_ALIGN;
      2'b10:   out_src = SRC_BYP;
      2'b11:   out_src = SRC_REF;
      default: out_src = SRC_HIZ;
    endcase
  end

  assign pll_en  = pwrdn_n;
  assign drv_en  = running && sel != 2'b01;
  assign fb_div  = (mul == 2'b00) ? 4'd4 : (mul == 2'b01) ? 4'd6 : 4'd8;
  assign pre_div = (mul == 2'b10) ? 2'd3 : 2'd1;
  assign settled = running && cnt == '0;

  always_comb begin
    if (pd) cnt_nxt = L_PWRUP;
    else begin
      cnt_nxt = (tick && cnt != '0) ? cnt - CW'(1) : cnt;
      if (mul_chg  && cnt_nxt < L_MULT)  cnt_nxt = L_MULT;
      if (sel_chg  && cnt_nxt < L_CTL)   cnt_nxt = L_CTL;
      if (stop_end && cnt_nxt < L_PHASE) cnt_nxt = L_PHASE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_stop_n <= stop_n;
      p_sel    <= sel;
      p_mul    <= mul;
      cnt      <= L_PWRUP;
      stop_cnt <= '0;
      run_cnt  <= L_RMIN;
      viol     <= '0;
    end else begin
      p_stop_n <= stop_n;
      p_sel    <= sel;
      p_mul    <= mul;
      cnt      <= cnt_nxt;
      if (stopped) begin
        if (tick && stop_cnt != L_SMAX) stop_cnt <= stop_cnt + SW'(1);
        if (tick && stop_cnt == L_SMAX) viol[0] <= 1'b1;
      end else stop_cnt <= '0;
      if (pd) run_cnt <= L_RMIN;
      else if (stopped) begin
        run_cnt <= '0;
        if (p_stop_n && run_cnt < L_RMIN) viol[1] <= 1'b1;
      end else if (tick && run_cnt != L_RMIN) run_cnt <= run_cnt + RW'(1);
      if (pwrdn_n && sel == 2'b11 && p_sel == 2'b11 && mul_chg) viol[2] <= 1'b1;
    end
  end

  p_pd_ground_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |-> out_src == SRC_GND && !drv_en && !pll_en && !settled);
  p_stop_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && !stop_n) |-> out_src == SRC_PARK && !drv_en && pll_en);
  p_div_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_div == 2'd3 |-> fb_div == 4'd8);
  p_pd_unsettled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrdn_n |=> !settled);
  p_mul_resettle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && mul != $past(mul)) |=> !settled);
  p_sel_resettle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrdn_n && sel != $past(sel)) |=> !settled);
  p_stop_unsettled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !settled);
  p_viol_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
    viol != 3'b000 |=> (viol & $past(viol)) == $past(viol));
endmodule

// File: tb/sim_clk_mode_ctrl.sv
module sim_clk_mode_ctrl;
  localparam int T_PWRUP = 12, T_MULT = 5, T_CTL = 9, T_PHASE = 4;
  localparam int T_STOP_MAX = 20, T_RUN_MIN = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrdn_n = 1'b1, stop_n = 1'b1, sel_a = 1'b0, sel_b = 1'b0, mul_a = 1'b0, mul_b = 1'b0;
  logic [2:0] out_src, viol;
  logic [3:0] fb_div;
  logic [1:0] pre_div;
  logic pll_en, drv_en, settled;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  clk_mode_ctrl #(.TICK_DIV(1), .T_PWRUP(T_PWRUP), .T_MULT(T_MULT), .T_CTL(T_CTL),
    .T_PHASE(T_PHASE), .T_STOP_MAX(T_STOP_MAX), .T_RUN_MIN(T_RUN_MIN)) u0 (
    .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .stop_n(stop_n), .sel_a(sel_a),
    .sel_b(sel_b), .mul_a(mul_a), .mul_b(mul_b), .out_src(out_src), .fb_div(fb_div),
    .pre_div(pre_div), .pll_en(pll_en), .drv_en(drv_en), .settled(settled), .viol(viol));

  function automatic int exp_src(logic pn, logic sn, logic a, logic b);
    if (!pn) return 0;
    if (!sn) return 1;
    case ({a, b})
      2'b00: return 2;
      2'b10: return 3;
      2'b11: return 4;
      default: return 5;
    endcase
  endfunction
  function automatic int exp_fb(logic a, logic b);
    return ({a, b} == 2'b00) ? 4 : ({a, b} == 2'b01) ? 6 : 8;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rise(int n, string tag);
    edges(n - 1);
    check({tag, " settled before"}, settled, 0);
    edges(1);
    check({tag, " settled at"}, settled, 1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwrdn_n = 1'b1; stop_n = 1'b1;
    sel_a = 1'b0; sel_b = 1'b0; mul_a = 1'b0; mul_b = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(T_PWRUP);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    edges(3);
    rst_n = 1'b1;
    check("R5 reset settled", settled, 0);
    check("R13 reset viol", viol, 0);
    check("R3 reset src", out_src, 2);
    expect_rise(T_PWRUP, "R5 reset");

    // random decode of R1 R2 R3 R4
    for (int i = 0; i < 200; i++) begin
      pwrdn_n = ($urandom % 4) != 0;
      stop_n  = ($urandom % 3) != 0;
      {sel_a, sel_b, mul_a, mul_b} = 4'($urandom);
      #2;
      check("R1R2R3 src", out_src, exp_src(pwrdn_n, stop_n, sel_a, sel_b));
      check("R1R2R3 drv_en", drv_en, pwrdn_n && stop_n && {sel_a, sel_b} != 2'b01);
      check("R1R2 pll_en", pll_en, pwrdn_n);
      check("R4 fb_div", fb_div, exp_fb(mul_a, mul_b));
      check("R4 pre_div", pre_div, ({mul_a, mul_b} == 2'b10) ? 3 : 1);
      if (!pwrdn_n) check("R1 settled", settled, 0);
      edges(1);
    end

    do_reset();
    mul_b = 1'b1;
    expect_rise(T_MULT + 1, "R6");
    check("R4 fb 6", fb_div, 6);
    sel_a = 1'b1;
    expect_rise(T_CTL + 1, "R7");
    check("R3 bypass", out_src, 3);

    sel_a = 1'b0;
    edges(3);
    mul_a = 1'b1;
    expect_rise(T_CTL + 1 - 3, "R9 sel then mul");
    mul_b = 1'b0;
    edges(2);
    sel_a = 1'b1;
    expect_rise(T_CTL + 1, "R9 mul then sel");
    sel_a = 1'b0; mul_a = 1'b0;
    expect_rise(T_CTL + 1, "R9 same cycle");

    stop_n = 1'b0;
    edges(1);
    check("R8 stop settled", settled, 0);
    check("R2 park", out_src, 1);
    edges(4);
    stop_n = 1'b1;
    expect_rise(T_PHASE + 1, "R8 stop exit");
    edges(T_RUN_MIN);
    stop_n = 1'b0;
    edges(T_STOP_MAX);
    stop_n = 1'b1;
    edges(1);
    check("R10 stop at limit", viol, 3'b000);
    edges(T_RUN_MIN + 1);
    stop_n = 1'b0;
    edges(T_STOP_MAX + 1);
    check("R10 stop over limit", viol, 3'b001);
    stop_n = 1'b1;
    edges(2);
    check("R13 sticky", viol, 3'b001);

    do_reset();
    check("R13 reset clears", viol, 3'b000);
    stop_n = 1'b0; edges(2);
    stop_n = 1'b1; edges(T_RUN_MIN);
    stop_n = 1'b0; edges(1);
    check("R11 run at min", viol, 3'b000);
    stop_n = 1'b1; edges(T_RUN_MIN - 1);
    stop_n = 1'b0; edges(1);
    check("R11 run short", viol, 3'b010);
    stop_n = 1'b1;

    do_reset();
    mul_b = 1'b1; edges(1);
    check("R12 normal mul change", viol, 3'b000);
    sel_a = 1'b1; sel_b = 1'b1;
    edges(T_CTL + 2);
    check("R3 reference", out_src, 4);
    mul_a = 1'b1; edges(1);
    check("R12 test mul change", viol, 3'b100);

    do_reset();
    pwrdn_n = 1'b0;
    edges(1);
    check("R1 ground", out_src, 0);
    check("R1 settled", settled, 0);
    stop_n = 1'b0; sel_a = 1'b1; sel_b = 1'b1;
    edges(1);
    mul_a = 1'b1;
    edges(T_STOP_MAX + 5);
    stop_n = 1'b1; edges(1);
    mul_b = 1'b1; edges(1);
    check("R1 ground held", out_src, 0);
    pwrdn_n = 1'b1;
    expect_rise(T_PWRUP, "R13 pd release");
    check("R13 pd no viol", viol, 3'b000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule